// File: doc/BRIEF.md
# Frame-Event VSYNC Generator

This block turns the frame start and frame end event strobes of a camera-style pixel stream into a vertical sync output. It runs entirely on the pixel clock. The block receives its configuration as static input ports. A register interface elsewhere drives those ports.

A mode bit picks one of two timing sources. In direct mode, each selected start or end strobe gives a single-cycle pulse. In internal mode, a frame end starts a counter that measures synthetic lines. The length of one synthetic line is a programmed value times sixteen clocks. After an offset of m such lines, the output is held active for n lines. A polarity bit sets the active level of the output.

Top module: `vsync_gen`

## Requirements
- R1: After reset the output is at its inactive level: low when `cfg_invert`=0, high when `cfg_invert`=1. No internal sequence is pending.
- R2: In direct mode (`cfg_internal`=0), a strobe gives exactly one active cycle, in the cycle after the strobe. `cfg_evt_sel[1]`=1 suppresses frame start pulses and `cfg_evt_sel[0]`=1 suppresses frame end pulses. So 00 selects both events, 01 start only, 10 end only and 11 neither.
- R3: `cfg_invert`=1 makes the output active-low. It takes effect in the same cycle it changes, in both modes.
- R4: One synthetic line lasts `cfg_line_len` x 16 clock cycles.
- R5: In internal mode, the output goes active `cfg_offset` x line cycles after the cycle that follows the frame end strobe. With an offset of zero, the output goes active in the cycle right after the strobe.
- R6: In internal mode, the output stays active for `cfg_width` x line cycles and then returns to inactive.
- R7: A frame end in internal mode with `cfg_line_len`=0 or `cfg_width`=0 produces no pulse and cancels any sequence in progress.
- R8: In internal mode, `cfg_evt_sel` and frame start strobes have no effect on the output.
- R9: A frame end in internal mode while a sequence is running restarts the offset count from zero, using the configuration present at that strobe.
- R10: Line length, offset and width are captured at the frame end that starts a sequence. A started sequence also runs to its end after a switch to direct mode. While it runs, direct pulses combine with it as a logical OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_i | input | 1 | Frame start strobe, one cycle |
| fe_i | input | 1 | Frame end strobe, one cycle |
| cfg_internal | input | 1 | 0 = direct mode, 1 = internal timing |
| cfg_evt_sel | input | 2 | Direct-mode event suppression (bit1 start, bit0 end) |
| cfg_invert | input | 1 | 1 = active-low output |
| cfg_line_len | input | 8 | Synthetic line length in units of 16 clocks |
| cfg_offset | input | 3 | Offset in synthetic lines before the pulse |
| cfg_width | input | 3 | Pulse width in synthetic lines |
| vsync_o | output | 1 | Vertical sync output |

## Verification
Two cases can fall in the same cycle, and the bench provokes both on purpose. In the first, a direct-mode pulse lands inside the active window of an internal sequence. The bench switches the mode to direct halfway through a sequence and strobes a frame start there. In the second, a restarting frame end arrives while the previous pulse is still active. A behavioural model in the bench tracks elapsed cycles from each frame end and predicts the output every clock. Each collision is judged by comparing the output with that model cycle by cycle, so a dropped OR term or a missed restart shows up at the exact cycle where it happens.

// File: rtl/vsync_gen.sv
module vsync_gen #(
  parameter int LEN_W     = 8,
  parameter int OFS_W     = 3,
  parameter int WID_W     = 3,
  parameter int MULT_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic             fe_i,
  input  logic             cfg_internal,
  input  logic [1:0]       cfg_evt_sel,
  input  logic             cfg_invert,
  input  logic [LEN_W-1:0] cfg_line_len,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [WID_W-1:0] cfg_width,
  output logic             vsync_o
);

  localparam int PER_W  = LEN_W + MULT_LOG2;
  localparam int LINE_W = ((OFS_W > WID_W) ? OFS_W : WID_W) + 1;

  logic              dir_q;
  logic              run_q;
  logic [PER_W-1:0]  pix_q, per_q;
  logic [LINE_W-1:0] line_q, last_q, ofs_q;

  wire              start   = fe_i && cfg_internal;
  wire              cfg_ok  = (cfg_line_len != '0) && (cfg_width != '0);
  wire [PER_W-1:0]  per_raw = {cfg_line_len, {MULT_LOG2{1'b0}}};
  wire              dir_hit = !cfg_internal &&
                              ((fs_i && !cfg_evt_sel[1]) || (fe_i && !cfg_evt_sel[0]));
  wire              seq_act = run_q && (line_q >= ofs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      run_q  <= 1'b0;
      pix_q  <= '0;
      per_q  <= '0;
      line_q <= '0;
      last_q <= '0;
      ofs_q  <= '0;
    end else begin
      dir_q <= dir_hit;
      if (start) begin
        run_q  <= cfg_ok;
        pix_q  <= '0;
        line_q <= '0;
        per_q  <= per_raw - PER_W'(1);
        ofs_q  <= LINE_W'(cfg_offset);
        last_q <= LINE_W'(cfg_offset) + LINE_W'(cfg_width) - LINE_W'(1);
      end else if (run_q) begin
        if (pix_q == per_q) begin
          pix_q <= '0;
          if (line_q == last_q) run_q  <= 1'b0;
          else                  line_q <= line_q + LINE_W'(1);
        end else begin
          pix_q <= pix_q + PER_W'(1);
        end
      end
    end
  end

  assign vsync_o = (dir_q | seq_act) ^ cfg_invert;

  assert_direct_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_internal && ((fs_i && !cfg_evt_sel[1]) || (fe_i && !cfg_evt_sel[0])))
      |=> (vsync_o != cfg_invert));

  assert_zero_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_ok && cfg_offset == '0) |=> (vsync_o != cfg_invert));

  assert_offset_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_offset != '0) |=> !seq_act);

  assert_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_ok) |=> !run_q);

  assert_pix_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pix_q <= per_q));

  assert_line_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (line_q <= last_q));

endmodule

// File: tb/sim_vsync_gen.sv
`timescale 1ns/1ps
module sim_vsync_gen;
  logic clk = 0, rst_n = 0, fs = 0, fe = 0, mode = 0, inv = 0;
  logic [1:0] sel = 0;
  logic [7:0] len = 0;
  logic [2:0] ofs = 0, wid = 0;
  logic vs;

  integer errors = 0, checks = 0, cyc = 0;
  string  tag = "R1";

  integer m_e, m_start, m_stop;
  bit     m_run, m_dir;

  always #4 clk = ~clk;

  vsync_gen u0 (.clk(clk), .rst_n(rst_n), .fs_i(fs), .fe_i(fe), .cfg_internal(mode),
                .cfg_evt_sel(sel), .cfg_invert(inv), .cfg_line_len(len),
                .cfg_offset(ofs), .cfg_width(wid), .vsync_o(vs));

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_run = 0; m_dir = 0; m_e = 0; m_start = 0; m_stop = 0;
    end else begin
      m_dir = !mode && ((fs && !sel[1]) || (fe && !sel[0]));
      if (fe && mode) begin
        m_run   = (len != 0) && (wid != 0);
        m_e     = 0;
        m_start = ofs * len * 16;
        m_stop  = (ofs + wid) * len * 16;
      end else if (m_run) begin
        m_e = m_e + 1;
        if (m_e >= m_stop) m_run = 0;
      end
    end
  end

  function automatic bit expect_vs();
    return (m_dir || (m_run && m_e >= m_start)) ^ inv;
  endfunction

  always @(negedge clk) begin
    #2;
    checks = checks + 1;
    if (vs !== expect_vs()) begin
      errors = errors + 1;
      $display("FAIL %s cycle %0d: vsync=%b expected=%b", tag, cyc, vs, expect_vs());
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic idle(input integer n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit s, input bit e);
    fs = s; fe = e; @(negedge clk); fs = 0; fe = 0;
  endtask

  task automatic cfg(input bit md, input logic [7:0] l, input logic [2:0] o, input logic [2:0] w);
    mode = md; len = l; ofs = o; wid = w;
  endtask

  initial begin
    tag = "R1";
    idle(3);
    checks = checks + 1;
    if (vs !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1 reset level: actual=%b expected=0", vs);
    end
    rst_n = 1;
    idle(2);

    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      pulse(1, 0); idle(3);
      pulse(0, 1); idle(3);
      pulse(1, 1); idle(2);
      pulse(1, 0); pulse(0, 1); idle(3);
    end
    sel = 0;

    tag = "R3";
    inv = 1; idle(2);
    pulse(1, 0); idle(3);
    sel = 2'b01; pulse(0, 1); idle(2);
    inv = 0; sel = 0; idle(2);

    tag = "R4";
    cfg(1, 1, 2, 3); pulse(0, 1); idle(100);
    tag = "R5";
    cfg(1, 2, 0, 1); pulse(0, 1); idle(45);
    cfg(1, 3, 1, 2); pulse(0, 1); idle(160);
    tag = "R6";
    cfg(1, 255, 1, 1); pulse(0, 1); idle(8200);
    cfg(1, 1, 7, 7); pulse(0, 1); idle(240);

    tag = "R7";
    cfg(1, 0, 1, 3); pulse(0, 1); idle(80);
    cfg(1, 2, 1, 0); pulse(0, 1); idle(80);
    cfg(1, 2, 0, 4); pulse(0, 1); idle(20);
    cfg(1, 0, 0, 4); pulse(0, 1); idle(150);

    tag = "R8";
    cfg(1, 1, 1, 2); sel = 2'b00; pulse(0, 1); idle(5);
    pulse(1, 0); sel = 2'b11; idle(20); pulse(1, 0); sel = 2'b10; idle(40);
    pulse(1, 0); idle(5); sel = 0;

    tag = "R9";
    cfg(1, 1, 1, 2); pulse(0, 1); idle(25);
    pulse(0, 1); idle(60);
    cfg(1, 1, 0, 3); pulse(0, 1); idle(10);
    cfg(1, 2, 2, 1); pulse(0, 1); idle(110);

    tag = "R10";
    cfg(1, 1, 1, 2); pulse(0, 1); idle(5);
    len = 9; ofs = 5; wid = 7; idle(60);
    cfg(1, 1, 0, 4); pulse(0, 1); idle(10);
    mode = 0; sel = 0; pulse(1, 0); idle(3); pulse(0, 1); idle(60);
    inv = 1; mode = 1; pulse(0, 1); idle(80);
    inv = 0; idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule